// File: doc/BRIEF.md
# Serial Controller Register and Status Unit

This unit is the register file and flag logic of an asynchronous serial port. It sits between a simple byte-wide register bus and two neighbours: a transmit shifter and a receive path. Software programs framing and rate, enables each direction, writes bytes to send and reads bytes received. The unit tracks the empty, end, full and error flags and raises four interrupt lines. The shifting itself and the bit timing live outside it. The smart-card and extended-mode registers are plain storage for those neighbours to decode.

Transmit bytes leave on a valid-only stream. `tx_valid` is high for exactly one clock with the byte on `tx_byte`, and the shifter must take it then. There is no back-pressure: a new byte is offered only when the shifter has reported the previous one done through `tx_sent`, or when the line was idle. Receive bytes arrive the same way on `rx_valid`/`rx_byte` and are never stalled. A byte that finds the holding register still full is dropped and flagged as an overrun. While receive is disabled, arriving bytes are discarded.

Top module: `sercore_top`

## Requirements
- R1: After reset, status reads 0x84, bit-rate reads 0xFF, transmit data reads 0xFF, and mode, control, receive data, smart-card and extended registers read 0x00.
- R2: Writes to mode (offset 0) and bit-rate (offset 1) take effect only while control bits 5 (transmit enable) and 4 (receive enable) are both 0. Smart-card (offset 6) and extended (offset 7) registers always read back what was written.
- R3: A control write (offset 2) with bit 5 set forces status bit 7 (transmit empty) and bit 2 (transmit end) to 1. If bit 7 of the written value (transmit interrupt enable) is set, `irq_tx` pulses.
- R4: A control write with bit 2 (transmit-end interrupt enable) clear drops `irq_tend`. A control write with bit 6 (receive interrupt enable) clear drops `irq_err`.
- R5: A write to transmit data (offset 3) while transmit end is 1 puts the byte on `tx_valid`/`tx_byte` on the next cycle, clears transmit end, leaves transmit empty at 1, and pulses `irq_tx` if enabled. While transmit end is 0, the write only stores the byte and clears transmit empty.
- R6: On `tx_sent`, a pending byte (transmit empty 0) is offered to the shifter and transmit empty returns to 1. With nothing pending, transmit end is set to 1 and `irq_tend` rises if control bit 2 is set.
- R7: A status write (offset 4) changes only bit 0 (multiprocessor transfer) and bits 5:3 (overrun, framing, parity). `irq_err` drops only if the most recent status read showed an error bit and the written error bits are all zero.
- R8: Reading receive data (offset 5) returns the held byte and clears status bit 6 (receive full). Writes to offset 5 are ignored.
- R9: With receive enabled and receive full clear, a byte on `rx_valid` is stored, sets receive full, and pulses `irq_rx` if receive interrupts are enabled. With receive disabled, the byte is ignored.
- R10: A byte arriving while receive full is set leaves the held byte unchanged, sets overrun (bit 5), and raises `irq_err` if receive interrupts are enabled.
- R11: `rx_break` sets framing error (bit 4) and raises `irq_err` if receive interrupts are enabled.
- R12: `irq_rx` and `irq_tx` are one-clock pulses. `irq_err` and `irq_tend` are levels that hold until cleared as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| tx_valid | output | 1 | One-cycle offer of a byte to the shifter |
| tx_byte | output | 8 | Byte offered to the shifter |
| tx_sent | input | 1 | Shifter finished the current byte |
| rx_valid | input | 1 | Receive path delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break condition detected |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_tend | output | 1 | Transmit-end interrupt level |
| irq_err | output | 1 | Error interrupt level |

## Verification
The bench targets the write lock on mode and bit-rate. A design without the lock would read back the locked-out value after enabling transmit. It checks that a data write with transmit end clear is held back until `tx_sent`; a wrong design would emit the byte at once or lose it, and the scoreboard would show a missing or extra byte. It checks that the error line clears only after a status read that saw an error, so a design that drops it on any zero write lowers `irq_err` too early. Overrun must keep the first byte, so a design that overwrites it returns the second byte on the receive data read.

// File: rtl/sercore_pkg.sv
package sercore_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    RG_MODE = 3'd0,
    RG_RATE = 3'd1,
    RG_CTRL = 3'd2,
    RG_TXD  = 3'd3,
    RG_STAT = 3'd4,
    RG_RXD  = 3'd5,
    RG_CARD = 3'd6,
    RG_EXT  = 3'd7
  } reg_sel_e;

  // control bits
  localparam int CB_TEIE = 2;
  localparam int CB_RE   = 4;
  localparam int CB_TE   = 5;
  localparam int CB_RIE  = 6;
  localparam int CB_TIE  = 7;

  // status bits
  localparam int SB_MPBT = 0;
  localparam int SB_TEND = 2;
  localparam int SB_PER  = 3;
  localparam int SB_FER  = 4;
  localparam int SB_OVR  = 5;
  localparam int SB_RDRF = 6;
  localparam int SB_TDRE = 7;

  localparam logic [DW-1:0] RATE_RST = 8'hFF;
  localparam logic [DW-1:0] TXD_RST  = 8'hFF;
endpackage

// File: rtl/sercore_cfg.sv
module sercore_cfg
  import sercore_pkg::*;
#(
  parameter int NUM_AUX = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                mode_q,
  output logic [DW-1:0]                rate_q,
  output logic [DW-1:0]                ctrl_q,
  output logic [NUM_AUX-1:0][DW-1:0]   aux_q
);
  logic locked;
  assign locked = ctrl_q[CB_TE] | ctrl_q[CB_RE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= RATE_RST;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (addr == RG_MODE && !locked) mode_q <= wdata;
      if (addr == RG_RATE && !locked) rate_q <= wdata;
      if (addr == RG_CTRL)            ctrl_q <= wdata;
    end
  end

  // storage-only registers follow the control block in the map
  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(RG_CARD) + i);
    always_ff @(posedge clk) begin
      if (!rst_n)                        aux_q[i] <= '0;
      else if (wr_en && addr == MY_ADDR) aux_q[i] <= wdata;
    end
  end

  assert_mode_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RG_MODE && locked) |=> $stable(mode_q));
  assert_rate_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RG_RATE && locked) |=> $stable(rate_q));
endmodule

// File: rtl/sercore_tx.sv
module sercore_tx
  import sercore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          new_te,
  input  logic          new_tie,
  input  logic          new_teie,
  input  logic          tie_q,
  input  logic          teie_q,
  input  logic          txd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_sent,
  output logic [DW-1:0] tdr_q,
  output logic          tdre_q,
  output logic          tend_q,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          txi_q,
  output logic          tei_q
);
  logic [DW-1:0] tdr_n;
  logic          tdre_n, tend_n, tei_n, txi_n, send;

  always_comb begin
    tdr_n  = tdr_q;
    tdre_n = tdre_q;
    tend_n = tend_q;
    tei_n  = tei_q;
    txi_n  = 1'b0;
    send   = 1'b0;
    if (ctl_wr) begin
      if (new_te) begin
        tdre_n = 1'b1;
        tend_n = 1'b1;
        if (new_tie) txi_n = 1'b1;
      end
      if (!new_teie) tei_n = 1'b0;
    end
    if (txd_wr) begin
      tdr_n = wdata;
      if (tend_q) send = 1'b1;
      else        tdre_n = 1'b0;
    end
    if (send) begin
      tend_n = 1'b0;
      tdre_n = 1'b1;
      tei_n  = 1'b0;
      if (tie_q) txi_n = 1'b1;
    end
    if (tx_sent && !send) begin
      if (!tdre_n) begin
        send   = 1'b1;
        tend_n = 1'b0;
        tdre_n = 1'b1;
        tei_n  = 1'b0;
        if (tie_q) txi_n = 1'b1;
      end else begin
        tend_n = 1'b1;
        if (teie_q) tei_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdr_q    <= TXD_RST;
      tdre_q   <= 1'b1;
      tend_q   <= 1'b1;
      tei_q    <= 1'b0;
      txi_q    <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tdr_q    <= tdr_n;
      tdre_q   <= tdre_n;
      tend_q   <= tend_n;
      tei_q    <= tei_n;
      txi_q    <= txi_n;
      tx_valid <= send;
      if (send) tx_byte <= tdr_n;
    end
  end

  assert_direct_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && tend_q && !tx_sent && !ctl_wr) |=> (tx_valid && !tend_q && tdre_q));
  assert_held_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !tend_q && !tx_sent && !ctl_wr) |=> (!tdre_q && !tx_valid));
  assert_tend_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sent && tdre_q && !txd_wr && !ctl_wr) |=> (tend_q && (tei_q == $past(teie_q || tei_q))));
endmodule

// File: rtl/sercore_rx.sv
module sercore_rx
  import sercore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re_q,
  input  logic          rie_q,
  input  logic          ctl_wr,
  input  logic          new_rie,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          wr_mpbt,
  input  logic [2:0]    wr_err,
  input  logic          rxd_rd,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  output logic [DW-1:0] rdr_q,
  output logic          rdrf_q,
  output logic [2:0]    err_q,
  output logic          mpbt_q,
  output logic          rxi_q,
  output logic          eri_q
);
  // err_q = {overrun, framing, parity}
  logic [DW-1:0] rdr_n;
  logic          rdrf_n, mpbt_n, eri_n, rxi_n;
  logic [2:0]    err_n, snap_q, snap_n;

  always_comb begin
    rdr_n  = rdr_q;
    rdrf_n = rdrf_q;
    err_n  = err_q;
    mpbt_n = mpbt_q;
    eri_n  = eri_q;
    snap_n = snap_q;
    rxi_n  = 1'b0;
    if (rxd_rd)  rdrf_n = 1'b0;
    if (stat_rd) snap_n = err_q;
    if (stat_wr) begin
      mpbt_n = wr_mpbt;
      err_n  = wr_err;
      if (snap_q != 3'b000 && wr_err == 3'b000) eri_n = 1'b0;
    end
    if (ctl_wr && !new_rie) eri_n = 1'b0;
    if (rx_valid && re_q) begin
      if (rdrf_q) begin
        err_n[2] = 1'b1;
        if (rie_q) eri_n = 1'b1;
      end else begin
        rdr_n  = rx_byte;
        rdrf_n = 1'b1;
        if (rie_q) rxi_n = 1'b1;
      end
    end
    if (rx_break) begin
      err_n[1] = 1'b1;
      if (rie_q) eri_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      err_q  <= '0;
      mpbt_q <= 1'b0;
      eri_q  <= 1'b0;
      rxi_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      rdr_q  <= rdr_n;
      rdrf_q <= rdrf_n;
      err_q  <= err_n;
      mpbt_q <= mpbt_n;
      eri_q  <= eri_n;
      rxi_q  <= rxi_n;
      snap_q <= snap_n;
    end
  end

  assert_rxi_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rxi_q |=> !rxi_q);
  assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && re_q && rdrf_q) |=> (err_q[2] && $stable(rdr_q)));
  assert_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> err_q[1]);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && !rx_valid) |=> !rdrf_q);
endmodule

// File: rtl/sercore_top.sv
module sercore_top
  import sercore_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_sent,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_break,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_tend,
  output logic          irq_err
);
  localparam int NUM_AUX = 2;

  logic [DW-1:0]              mode_q, rate_q, ctrl_q, tdr_q, rdr_q;
  logic [NUM_AUX-1:0][DW-1:0] aux_q;
  logic                       tdre_q, tend_q, rdrf_q, mpbt_q;
  logic [2:0]                 err_q;
  logic                       ctl_wr, txd_wr, stat_wr, stat_rd, rxd_rd;

  assign ctl_wr  = bus_wr && bus_addr == RG_CTRL;
  assign txd_wr  = bus_wr && bus_addr == RG_TXD;
  assign stat_wr = bus_wr && bus_addr == RG_STAT;
  assign stat_rd = bus_rd && bus_addr == RG_STAT;
  assign rxd_rd  = bus_rd && bus_addr == RG_RXD;

  sercore_cfg #(.NUM_AUX(NUM_AUX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .rate_q(rate_q), .ctrl_q(ctrl_q), .aux_q(aux_q)
  );

  sercore_tx u_tx (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .new_te(bus_wdata[CB_TE]), .new_tie(bus_wdata[CB_TIE]), .new_teie(bus_wdata[CB_TEIE]),
    .tie_q(ctrl_q[CB_TIE]), .teie_q(ctrl_q[CB_TEIE]),
    .txd_wr(txd_wr), .wdata(bus_wdata), .tx_sent(tx_sent),
    .tdr_q(tdr_q), .tdre_q(tdre_q), .tend_q(tend_q),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .txi_q(irq_tx), .tei_q(irq_tend)
  );

  sercore_rx u_rx (
    .clk(clk), .rst_n(rst_n), .re_q(ctrl_q[CB_RE]), .rie_q(ctrl_q[CB_RIE]),
    .ctl_wr(ctl_wr), .new_rie(bus_wdata[CB_RIE]),
    .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wr_mpbt(bus_wdata[SB_MPBT]), .wr_err(bus_wdata[SB_OVR:SB_PER]),
    .rxd_rd(rxd_rd), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rdr_q(rdr_q), .rdrf_q(rdrf_q), .err_q(err_q), .mpbt_q(mpbt_q),
    .rxi_q(irq_rx), .eri_q(irq_err)
  );

  always_comb begin
    unique case (bus_addr)
      RG_MODE: bus_rdata = mode_q;
      RG_RATE: bus_rdata = rate_q;
      RG_CTRL: bus_rdata = ctrl_q;
      RG_TXD:  bus_rdata = tdr_q;
      RG_STAT: bus_rdata = {tdre_q, rdrf_q, err_q, tend_q, 1'b0, mpbt_q};
      RG_RXD:  bus_rdata = rdr_q;
      RG_CARD: bus_rdata = aux_q[0];
      default: bus_rdata = aux_q[1];
    endcase
  end

  assert_stat_write_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_valid && !rx_break && !rxd_rd && !tx_sent) |=>
      ($stable(tdre_q) && $stable(tend_q) && $stable(rdrf_q)));
  assert_te_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CB_TE]) |=> (tdre_q && tend_q));
endmodule

// File: tb/sercore_top_test.sv
module sercore_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       tx_sent = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       irq_rx, irq_tx, irq_tend, irq_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sercore_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_sent(tx_sent), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_tend(irq_tend), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the transmit stream (R5, R6)
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6 stream: actual %h expected none", tx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_byte !== e) begin
          fails++;
          $display("FAIL R5/R6 stream: actual %h expected %h", tx_byte, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic send_byte(input logic [7:0] d);
    exp_q.push_back(d);
    wr(3'd3, d);
  endtask

  task automatic pulse_sent();
    @(negedge clk); tx_sent = 1'b1;
    @(negedge clk); tx_sent = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_byte = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_chk(3'd0, 8'h00, "R1 mode");
    rd_chk(3'd1, 8'hFF, "R1 rate");
    rd_chk(3'd2, 8'h00, "R1 ctrl");
    rd_chk(3'd3, 8'hFF, "R1 txd");
    rd_chk(3'd4, 8'h84, "R1 stat");
    rd_chk(3'd5, 8'h00, "R1 rxd");
    rd_chk(3'd6, 8'h00, "R1 card");
    rd_chk(3'd7, 8'h00, "R1 ext");
    // R2 unlocked writes and storage registers
    wr(3'd0, 8'h5A); rd_chk(3'd0, 8'h5A, "R2 mode open");
    wr(3'd1, 8'h33); rd_chk(3'd1, 8'h33, "R2 rate open");
    wr(3'd6, 8'hA5); rd_chk(3'd6, 8'hA5, "R2 card");
    wr(3'd7, 8'h3C); rd_chk(3'd7, 8'h3C, "R2 ext");
    // R3 enable transmit with its interrupt
    wr(3'd2, 8'hA0);
    chk("R3 txi pulse", {7'd0, irq_tx}, 8'h01);
    @(negedge clk);
    chk("R12 txi width", {7'd0, irq_tx}, 8'h00);
    rd_chk(3'd4, 8'h84, "R3 stat");
    // R2 locked
    wr(3'd0, 8'h11); rd_chk(3'd0, 8'h5A, "R2 mode locked");
    wr(3'd1, 8'h22); rd_chk(3'd1, 8'h33, "R2 rate locked");
    // R5 direct send
    send_byte(8'h41);
    chk("R5 txi on send", {7'd0, irq_tx}, 8'h01);
    rd_chk(3'd4, 8'h80, "R5 stat after send");
    // R5 held byte
    wr(3'd3, 8'h42);
    rd_chk(3'd4, 8'h00, "R5 stat held");
    chk("R5 queue not drained", 8'(exp_q.size()), 8'h00);
    exp_q.push_back(8'h42);
    // R6 shifter done with pending byte, then with none
    pulse_sent();
    rd_chk(3'd4, 8'h80, "R6 pending sent");
    pulse_sent();
    rd_chk(3'd4, 8'h84, "R6 tend set");
    chk("R6 no tend irq when disabled", {7'd0, irq_tend}, 8'h00);
    // R6 / R4 transmit-end interrupt
    wr(3'd2, 8'h24);
    wr(3'd3, 8'h55); exp_q.push_back(8'h00); void'(exp_q.pop_back()); exp_q.push_back(8'h55);
    pulse_sent();
    chk("R6 tend irq", {7'd0, irq_tend}, 8'h01);
    wr(3'd2, 8'h20);
    chk("R4 tend irq drop", {7'd0, irq_tend}, 8'h00);
    // R9 receive
    wr(3'd2, 8'h50);
    rx_push(8'h99);
    chk("R9 rxi", {7'd0, irq_rx}, 8'h01);
    @(negedge clk);
    chk("R12 rxi width", {7'd0, irq_rx}, 8'h00);
    rd_chk(3'd4, 8'hC4, "R9 stat full");
    rd_chk(3'd5, 8'h99, "R8 rxd");
    rd_chk(3'd4, 8'h84, "R8 full cleared");
    wr(3'd5, 8'h00); rd_chk(3'd5, 8'h99, "R8 write ignored");
    // R10 overrun
    rx_push(8'h10);
    rx_push(8'h20);
    chk("R10 eri", {7'd0, irq_err}, 8'h01);
    rd_chk(3'd4, 8'hE4, "R10 stat");
    rd_chk(3'd5, 8'h10, "R10 first byte kept");
    // R7 clear after read showing error
    wr(3'd4, 8'h00);
    chk("R7 eri drop", {7'd0, irq_err}, 8'h00);
    rd_chk(3'd4, 8'h84, "R7 stat cleared");
    wr(3'd4, 8'hC5);
    rd_chk(3'd4, 8'h85, "R7 only mpbt and errors");
    wr(3'd4, 8'h01);
    rd_chk(3'd4, 8'h85, "R7 mpbt held");
    // R11 break; R7 no drop without error read
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    chk("R11 eri", {7'd0, irq_err}, 8'h01);
    wr(3'd4, 8'h01);
    chk("R7 eri kept without read", {7'd0, irq_err}, 8'h01);
    wr(3'd2, 8'h10);
    chk("R4 eri drop", {7'd0, irq_err}, 8'h00);
    // R11 status bit then R9 ignored when disabled
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd_chk(3'd4, 8'h95, "R11 fer bit");
    chk("R11 no eri when disabled", {7'd0, irq_err}, 8'h00);
    wr(3'd2, 8'h00);
    rx_push(8'h77);
    rd_chk(3'd4, 8'h95, "R9 ignored stat");
    rd_chk(3'd5, 8'h10, "R9 ignored rxd");
    repeat (2) @(negedge clk);
    chk("R5 stream drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule